// File: doc/BRIEF.md
# T1/E1 Receive Frame Pulse Generator

This block drives the system-side frame pulse of a receive path that runs as clock master. An upstream framer tells it, bit by bit, where each frame starts and where each multiframe boundary falls. The block turns these indications into a single pulse output at a cadence picked by the mode inputs. The receive clock may be gapped, so a clock-enable input marks the cycles that carry a bit. The pulse moves only on those enabled cycles and holds its level through the gaps.

A standard-select input chooses between T1 and E1 cadence tables, and a two-bit cadence code picks one entry from the chosen table. In T1 the pulse can mark every F-bit, every second F-bit, each superframe or extended superframe start, or every second superframe start. In E1 it can mark each basic frame, each CRC multiframe start, each signaling multiframe start, or any start of either multiframe kind. A polarity input sets the level the pulse takes when it is active.

Top module: `fpg_frame_pulse`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pulse state and both alternation counters clear. The output then sits at its inactive level, which is the inverse of `pol_high`. The first qualifying event after reset is the one that gets marked.
- R2: On a clock edge where `clk_en` is 0, the output level and the alternation counters keep their values, whatever the other inputs are doing.
- R3: With `std_e1`=0 and `cad_sel`=0, each enabled cycle with `frm_start`=1 makes the pulse active.
- R4: With `std_e1`=0 and `cad_sel`=1, only every second enabled frame start is marked, beginning with the first one after reset. This frame alternation advances on every enabled frame start, in any mode.
- R5: With `std_e1`=0 and `cad_sel`=2, the pulse marks each enabled frame start that comes with `t1_mf_start`=1.
- R6: With `std_e1`=0 and `cad_sel`=3, only every second T1 multiframe start is marked, beginning with the first one after reset. This multiframe alternation advances on every enabled cycle with both `frm_start` and `t1_mf_start` high, in any mode.
- R7: With `std_e1`=1 and `cad_sel`=0, each enabled frame start is marked.
- R8: With `std_e1`=1, `cad_sel`=1 marks frame starts that come with `e1_crc_mf_start`=1, and `cad_sel`=2 marks frame starts that come with `e1_sig_mf_start`=1.
- R9: With `std_e1`=1 and `cad_sel`=3, a frame start is marked when either E1 multiframe indication is high.
- R10: Multiframe indications have no effect when `frm_start` is low. An indication that belongs to the standard not currently selected is never marked.
- R11: With `pol_high`=1 the output is high while the pulse is active. With `pol_high`=0 it is low while active. A change of `pol_high` shows on the output without waiting for a clock edge.
- R12: The pulse becomes active at the enabled edge that samples the marked frame start. It drops at the next enabled edge unless that edge samples another marked frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | High on cycles that carry a bit (gapped-clock qualifier) |
| std_e1 | input | 1 | 0 selects the T1 cadence table, 1 selects the E1 cadence table |
| cad_sel | input | 2 | Cadence code within the selected table |
| pol_high | input | 1 | 1 for an active-high pulse, 0 for an active-low pulse |
| frm_start | input | 1 | Framer: current bit is the first bit of a frame |
| t1_mf_start | input | 1 | Framer: current T1 frame opens a superframe or extended superframe |
| e1_crc_mf_start | input | 1 | Framer: current E1 frame opens a CRC multiframe |
| e1_sig_mf_start | input | 1 | Framer: current E1 frame opens a signaling multiframe |
| fp_out | output | 1 | Frame pulse at the selected polarity |

## Verification
A frame-start stimulus appears on `fp_out` exactly one enabled clock edge after it is presented. A polarity change needs no edge at all. The bench drives each stimulus at a falling edge and samples the output at the next falling edge, so exactly one rising edge lies between stimulus and check. A vector with the enable low is expected to show the previous level unchanged. The expected levels in the table were worked out by carrying both alternation phases from one row to the next, starting from the cleared state after reset. The directed tests that follow reset a running alternation and confirm that the next qualifying event is marked.

// File: rtl/fpg_pkg.sv
// Package: shared cadence codes for the frame pulse generator.
// Assumes the same two-bit code space is reused by the T1 and E1 tables.
package fpg_pkg;

    localparam int CAD_W = 2;

    typedef enum logic [CAD_W-1:0] {
        T1_EACH_F    = 2'd0,
        T1_ALT_F     = 2'd1,
        T1_EACH_MF   = 2'd2,
        T1_ALT_MF    = 2'd3
    } t1_cad_e;

    typedef enum logic [CAD_W-1:0] {
        E1_EACH_FRM  = 2'd0,
        E1_CRC_MF    = 2'd1,
        E1_SIG_MF    = 2'd2,
        E1_ANY_MF    = 2'd3
    } e1_cad_e;

endpackage

// File: rtl/fpg_nth_gate.sv
// Module: passes one event out of every DIV qualified events.
// The first event after reset passes. The count advances only when both
// the clock enable and the event are high.
// Assumes DIV >= 1. With DIV == 1 every event passes and no state is kept.
module fpg_nth_gate #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic event_i,
    output logic hit_o
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    generate
        if (DIV == 1) begin : g_pass
            // Every event passes; no count to keep.
            assign hit_o = event_i;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;

            // Count qualified events modulo DIV.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clk_en && event_i) begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                end
            end

            // The event passes while the count sits at its start phase.
            assign hit_o = event_i && (cnt_q == '0);

            p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= LAST);

            p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !clk_en |=> $stable(cnt_q));

            p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (clk_en && event_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
        end
    endgenerate

endmodule

// File: rtl/fpg_cadence_sel.sv
// Module: combinational choice of the frame start to be marked.
// Assumes every candidate input is already qualified by the frame start.
module fpg_cadence_sel
    import fpg_pkg::*;
(
    input  logic             std_e1,
    input  logic [CAD_W-1:0] cad_sel,
    input  logic             each_frm,
    input  logic             alt_frm,
    input  logic             t1_mf,
    input  logic             t1_alt_mf,
    input  logic             e1_crc,
    input  logic             e1_sig,
    output logic             mark_o
);

    t1_cad_e t1_cad;
    e1_cad_e e1_cad;

    assign t1_cad = t1_cad_e'(cad_sel);
    assign e1_cad = e1_cad_e'(cad_sel);

    // Pick the candidate named by the code in the active table.
    always_comb begin
        mark_o = 1'b0;
        if (!std_e1) begin
            case (t1_cad)
                T1_EACH_F:  mark_o = each_frm;
                T1_ALT_F:   mark_o = alt_frm;
                T1_EACH_MF: mark_o = t1_mf;
                T1_ALT_MF:  mark_o = t1_alt_mf;
                default:    mark_o = 1'b0;
            endcase
        end else begin
            case (e1_cad)
                E1_EACH_FRM: mark_o = each_frm;
                E1_CRC_MF:   mark_o = e1_crc;
                E1_SIG_MF:   mark_o = e1_sig;
                E1_ANY_MF:   mark_o = e1_crc || e1_sig;
                default:     mark_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fpg_pulse_reg.sv
// Module: holds the pulse for one enabled cycle and applies the output level.
// Assumes mark_i is sampled only on enabled edges. Polarity is applied after
// the register, so a polarity change shows at once.
module fpg_pulse_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic mark_i,
    input  logic pol_high,
    output logic active_o,
    output logic pin_o
);

    logic pulse_q;

    // Capture the mark on enabled edges; hold through clock gaps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else if (clk_en) begin
            pulse_q <= mark_i;
        end
    end

    // Drive the pin at the requested level.
    assign pin_o    = pol_high ? pulse_q : ~pulse_q;
    assign active_o = pulse_q;

    p_gap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(pulse_q));

    p_one_wide_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && clk_en && !mark_i) |=> !pulse_q);

endmodule

// File: rtl/fpg_frame_pulse.sv
// Module: top of the T1/E1 receive frame pulse generator (clock-master side).
// Takes frame and multiframe position flags from a framer and produces a
// one-enabled-cycle frame pulse at the selected cadence and polarity.
// Assumes the flags are aligned with the bit presented on the same enabled
// cycle, and multiframe flags count only together with frm_start.
module fpg_frame_pulse
    import fpg_pkg::*;
#(
    parameter int FRM_DIV = 2,
    parameter int MF_DIV  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             std_e1,
    input  logic [CAD_W-1:0] cad_sel,
    input  logic             pol_high,
    input  logic             frm_start,
    input  logic             t1_mf_start,
    input  logic             e1_crc_mf_start,
    input  logic             e1_sig_mf_start,
    output logic             fp_out
);

    logic t1_mf_q_n;
    logic crc_q_n;
    logic sig_q_n;
    logic alt_frm;
    logic alt_mf;
    logic mark;
    logic active;

    // Multiframe flags count only at the first bit of a frame.
    assign t1_mf_q_n = frm_start && t1_mf_start;
    assign crc_q_n   = frm_start && e1_crc_mf_start;
    assign sig_q_n   = frm_start && e1_sig_mf_start;

    fpg_nth_gate #(.DIV(FRM_DIV)) u_frm_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .event_i (frm_start),
        .hit_o   (alt_frm)
    );

    fpg_nth_gate #(.DIV(MF_DIV)) u_mf_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .event_i (t1_mf_q_n),
        .hit_o   (alt_mf)
    );

    fpg_cadence_sel u_sel (
        .std_e1    (std_e1),
        .cad_sel   (cad_sel),
        .each_frm  (frm_start),
        .alt_frm   (alt_frm),
        .t1_mf     (t1_mf_q_n),
        .t1_alt_mf (alt_mf),
        .e1_crc    (crc_q_n),
        .e1_sig    (sig_q_n),
        .mark_o    (mark)
    );

    fpg_pulse_reg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .mark_i   (mark),
        .pol_high (pol_high),
        .active_o (active),
        .pin_o    (fp_out)
    );

    p_needs_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(clk_en && frm_start));

    p_t1_each_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && frm_start && !std_e1 && cad_sel == 2'd0) |=> active);

    p_e1_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && frm_start && std_e1 && cad_sel == 2'd3 &&
         (e1_crc_mf_start || e1_sig_mf_start)) |=> active);

    p_pol_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (fp_out == pol_high));

endmodule

// File: tb/sim_fpg_frame_pulse.sv
`timescale 1ns/1ps
module sim_fpg_frame_pulse;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       std_e1 = 1'b0;
    logic [1:0] cad_sel = 2'd0;
    logic       pol_high = 1'b1;
    logic       frm_start = 1'b0;
    logic       t1_mf_start = 1'b0;
    logic       e1_crc_mf_start = 1'b0;
    logic       e1_sig_mf_start = 1'b0;
    logic       fp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpg_frame_pulse u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .clk_en          (clk_en),
        .std_e1          (std_e1),
        .cad_sel         (cad_sel),
        .pol_high        (pol_high),
        .frm_start       (frm_start),
        .t1_mf_start     (t1_mf_start),
        .e1_crc_mf_start (e1_crc_mf_start),
        .e1_sig_mf_start (e1_sig_mf_start),
        .fp_out          (fp_out)
    );

    // Row: {e1, cad[1:0], pol, en, frm, t1mf, crc, sig, expected fp_out}
    localparam int NV = 33;
    localparam logic [9:0] VEC [NV] = '{
        10'b0_00_1_1_1_000_1, // 1  R3 each F
        10'b0_00_1_1_0_000_0, // 2  R12 drops
        10'b0_00_1_0_1_000_0, // 3  R2 gap ignores frame
        10'b0_00_1_1_1_000_1, // 4  R3
        10'b0_00_1_0_0_000_1, // 5  R2 held in gap
        10'b0_00_1_1_0_000_0, // 6  R12
        10'b0_01_1_1_1_000_1, // 7  R4 marked
        10'b0_01_1_1_1_000_0, // 8  R4 skipped
        10'b0_01_1_1_1_000_1, // 9  R4 marked
        10'b0_01_1_1_0_000_0, // 10 R4
        10'b0_10_1_1_1_100_1, // 11 R5
        10'b0_10_1_1_1_000_0, // 12 R5 no mf
        10'b0_10_1_1_0_100_0, // 13 R10 mf without frame
        10'b0_11_1_1_1_100_0, // 14 R6 skipped
        10'b0_11_1_1_1_100_1, // 15 R6 marked
        10'b0_11_1_1_1_000_0, // 16 R6 plain frame
        10'b0_11_1_1_1_100_0, // 17 R6 skipped
        10'b0_11_1_1_1_100_1, // 18 R6 marked
        10'b1_00_1_1_1_000_1, // 19 R7
        10'b1_00_1_1_0_010_0, // 20 R10
        10'b1_01_1_1_1_010_1, // 21 R8 crc
        10'b1_01_1_1_1_001_0, // 22 R8 sig under crc code
        10'b1_10_1_1_1_001_1, // 23 R8 sig
        10'b1_10_1_1_1_010_0, // 24 R8 crc under sig code
        10'b1_11_1_1_1_010_1, // 25 R9 crc
        10'b1_11_1_1_1_001_1, // 26 R9 sig
        10'b1_11_1_1_1_000_0, // 27 R9 none
        10'b1_11_1_1_0_011_0, // 28 R10 no frame
        10'b1_10_1_1_1_100_0, // 29 R10 T1 flag in E1
        10'b0_00_0_1_1_000_0, // 30 R11 active low
        10'b0_00_0_1_0_000_1, // 31 R11 idle high
        10'b0_00_0_0_1_000_1, // 32 R2 gap, low pol
        10'b0_00_1_0_0_000_0  // 33 R11 pol flip, no edge
    };

    task automatic check(input string req, input logic exp_v);
        checks++;
        if (fp_out !== exp_v) begin
            errors++;
            $display("FAIL %s: fp_out=%b expected=%b at %0t", req, fp_out, exp_v, $time);
        end
    endtask

    task automatic drive(input logic [9:0] v);
        std_e1          = v[9];
        cad_sel         = v[8:7];
        pol_high        = v[6];
        clk_en          = v[5];
        frm_start       = v[4];
        t1_mf_start     = v[3];
        e1_crc_mf_start = v[2];
        e1_sig_mf_start = v[1];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, active-high and active-low idle levels
        @(negedge clk);
        drive(10'b0_00_1_1_1_000_0);
        @(negedge clk);
        check("R1 idle low", 1'b0);
        pol_high = 1'b0;
        #0.5;
        check("R1 idle high", 1'b1);
        pol_high = 1'b1;
        rst_n = 1'b1;
        drive(10'b0_00_1_0_0_000_0);
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            if (VEC[i][5] == 1'b0 && i == NV - 1) #0.5;
            else @(negedge clk);
            check($sformatf("R table row %0d", i + 1), VEC[i][0]);
        end

        // R1: reset wins over a frame start and clears the pulse
        drive(10'b0_00_1_1_1_000_0);
        @(negedge clk);
        check("R3 pulse before reset", 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears pulse", 1'b0);
        rst_n = 1'b1;

        // R1/R4: advance frame alternation, reset, first frame is marked
        drive(10'b0_01_1_1_1_000_0);
        @(negedge clk);
        check("R4 first after reset", 1'b1);
        rst_n = 1'b0;
        drive(10'b0_01_1_0_0_000_0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(10'b0_01_1_1_1_000_0);
        @(negedge clk);
        check("R1 alternation cleared", 1'b1);

        // R6: multiframe alternation cleared by reset
        drive(10'b0_11_1_1_1_100_0);
        @(negedge clk);
        check("R6 first mf after reset", 1'b1);
        rst_n = 1'b0;
        drive(10'b0_11_1_0_0_000_0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(10'b0_11_1_1_1_100_0);
        @(negedge clk);
        check("R1 mf alternation cleared", 1'b1);

        // R2: long gap holds the pulse level
        drive(10'b0_11_1_0_1_100_0);
        repeat (5) @(negedge clk);
        check("R2 long gap hold", 1'b1);
        drive(10'b0_11_1_1_1_100_0);
        @(negedge clk);
        check("R6 gap did not advance count", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule